// File: doc/BRIEF.md
# Time-Slotted Two-Port Memory Arbiter

This block lets two independent clients share the single host-side interface of one memory controller. Each client has its own reset, read and write strobes, address, write data and read data. Each also gets its own set of handshake indications: begun, early begun, done, read done and read pending. A client therefore sees a private read/write path and never observes the other client's traffic.

Access is scheduled by a fixed table of slots given as a parameter, one bit per slot. A bit set to 1 gives that slot to port 1 and a bit cleared to 0 gives it to port 0. A slot pointer advances once per clock and wraps, so the share of bandwidth a port receives follows the number of slots it owns. A slot whose owner is idle is lent to the other port. Once a request has been put on the controller interface, the grant stays with that port until the controller reports begun.

Every operation that begins is recorded with a small tag: the issuing port and whether it is a read. Tags are kept oldest first. The controller's done, read done and read data are steered back using the oldest tag, which lets a pipelined controller complete reads after the slot pointer has moved on. Memory timing and refresh are handled by the controller downstream.

Top module: `tslot_mem_arbiter`

## Requirements
- R1: While `rst_n` is low with all client strobes idle, `mc_rd` and `mc_wr` are low, and every per-port begun, early-begun, done, read-done and read-pending output is low.
- R2: When both ports request on every cycle and the controller begins every request in the cycle it is presented, the sequence of granted ports over any 16 consecutive cycles is a cyclic rotation of `SLOT_MAP`, where bit value 1 means port 1 and 0 means port 0. The number of port-1 grants in the window equals the number of set bits in `SLOT_MAP`.
- R3: A port requesting alone is granted on every cycle, including cycles whose slot belongs to the other port.
- R4: After a request is presented on `mc_rd`/`mc_wr` without `mc_begun`, the same port keeps the controller interface on following cycles until `mc_begun` is seen.
- R5: `mc_begun` and `mc_early_begun` are returned only to the port whose request is on the controller interface in that cycle; the other port sees them low.
- R6: Read completions are returned in begun order. `mc_rd_done` and `mc_rdata` go to the port that issued the oldest outstanding operation. The other port sees its read done low and its read data at all zeros.
- R7: `mc_done` is returned to the port that issued the oldest outstanding operation, whether that operation is a read or a write. `mc_done` also retires that operation.
- R8: A port's read-pending output is high from the cycle after one of its reads begins until the cycle after that read is retired. Writes do not raise it.
- R9: When `TAG_DEPTH` operations are outstanding, no new request is presented to the controller until a done retires one.
- R10: While a port's own reset input is low, its read and write requests are ignored and it receives no begun.
- R11: `mc_addr` and `mc_wdata` carry the granted port's address and data. Both are zero when no port is granted, whatever the idle ports drive.
- R12: A port asserting read and write together is issued as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the arbiter |
| p0_rst_n | input | 1 | Port 0 reset, active low; masks its requests |
| p0_rd | input | 1 | Port 0 read request |
| p0_wr | input | 1 | Port 0 write request |
| p0_addr | input | ADDR_W | Port 0 address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_begun | output | 1 | Port 0 operation begun |
| p0_early_begun | output | 1 | Port 0 early begun |
| p0_done | output | 1 | Port 0 operation done |
| p0_rd_done | output | 1 | Port 0 read done |
| p0_rd_pending | output | 1 | Port 0 has an outstanding read |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_rst_n | input | 1 | Port 1 reset, active low; masks its requests |
| p1_rd | input | 1 | Port 1 read request |
| p1_wr | input | 1 | Port 1 write request |
| p1_addr | input | ADDR_W | Port 1 address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_begun | output | 1 | Port 1 operation begun |
| p1_early_begun | output | 1 | Port 1 early begun |
| p1_done | output | 1 | Port 1 operation done |
| p1_rd_done | output | 1 | Port 1 read done |
| p1_rd_pending | output | 1 | Port 1 has an outstanding read |
| p1_rdata | output | DATA_W | Port 1 read data |
| mc_rd | output | 1 | Read request to controller |
| mc_wr | output | 1 | Write request to controller |
| mc_addr | output | ADDR_W | Address to controller |
| mc_wdata | output | DATA_W | Write data to controller |
| mc_begun | input | 1 | Controller: operation begun |
| mc_early_begun | input | 1 | Controller: early begun |
| mc_done | input | 1 | Controller: oldest operation done |
| mc_rd_done | input | 1 | Controller: oldest read done |
| mc_rdata | input | DATA_W | Controller read data |

## Verification
The assertions check several properties on every cycle:
- begun never reaches both ports at once;
- a read done only reaches a port whose read is outstanding;
- read data stays zero outside its read done;
- the controller never sees read and write together;
- a presented but not yet begun grant does not move;
- a port held in reset never gets begun.

Other behaviours can only be shown by the bench's scenarios:
- that the grant sequence is a rotation of the slot table;
- that an idle owner's slot is lent to the other port;
- that completions return in begun order to the right port, even when they arrive after the slot has passed;
- that requests stall while all tags are outstanding.

// File: rtl/tslot_pkg.sv
// Shared types for the time-slotted two-port memory arbiter.
// Assumes exactly two client ports; the port identifier is one bit.
package tslot_pkg;

    localparam int NUM_PORTS = 2;

    // Identifies a client port; the encoding matches a slot-table bit.
    typedef enum logic {
        PORT0 = 1'b0,
        PORT1 = 1'b1
    } port_id_e;

    // Record kept for each operation the controller has begun.
    typedef struct packed {
        port_id_e owner;
        logic     is_rd;
    } op_tag_t;

endpackage

// File: rtl/tslot_sched.sv
// Slot scheduler: walks the slot table one entry per clock and picks the
// port whose request goes to the controller this cycle.
// Assumes: a request is held by its client until begun; hold_off masks
// all grants (set when no tag space is left).
module tslot_sched
    import tslot_pkg::*;
#(
    parameter int             SLOTS    = 16,
    parameter logic [SLOTS-1:0] SLOT_MAP = 16'hC0F0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req,
    input  logic                 hold_off,
    input  logic                 mc_begun,
    output logic                 gnt_valid,
    output port_id_e             gnt_port
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);

    logic [PTR_W-1:0] slot_ptr;
    logic             locked;
    port_id_e         lock_port;
    port_id_e         owner;
    port_id_e         other;
    logic             pick_valid;
    port_id_e         pick_port;

    // Advance the slot pointer every cycle, wrapping at the table end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_ptr <= '0;
        end else if (slot_ptr == LAST_SLOT) begin
            slot_ptr <= '0;
        end else begin
            slot_ptr <= slot_ptr + 1'b1;
        end
    end

    assign owner = port_id_e'(SLOT_MAP[slot_ptr]);
    assign other = (owner == PORT0) ? PORT1 : PORT0;

    // Choose the locked port, else the slot owner, else the idle owner's peer.
    always_comb begin
        pick_port  = owner;
        pick_valid = 1'b0;
        if (locked) begin
            pick_port  = lock_port;
            pick_valid = req[lock_port];
        end else if (req[owner]) begin
            pick_port  = owner;
            pick_valid = 1'b1;
        end else if (req[other]) begin
            pick_port  = other;
            pick_valid = 1'b1;
        end
    end

    assign gnt_valid = pick_valid & ~hold_off;
    assign gnt_port  = pick_port;

    // Keep the grant on a presented request until the controller begins it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            lock_port <= PORT0;
        end else begin
            locked    <= gnt_valid & ~mc_begun;
            lock_port <= gnt_port;
        end
    end

endmodule

// File: rtl/tslot_tag_fifo.sv
// Ordered store of tags for operations the controller has begun.
// Pushed on begun, popped on done; the oldest tag steers completions.
// Assumes done never arrives in the same cycle as the begun it retires.
module tslot_tag_fifo
    import tslot_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  op_tag_t              push_tag,
    input  logic                 pop,
    output op_tag_t              head_tag,
    output logic                 head_valid,
    output logic                 full,
    output logic [NUM_PORTS-1:0] rd_pend
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DEPTH-1:0] vld_w;
    op_tag_t          tag_w [DEPTH];
    logic [DEPTH-1:0] rd_hit0;
    logic [DEPTH-1:0] rd_hit1;
    logic             do_push;
    logic             do_pop;

    assign head_valid = vld_w[rd_idx];
    assign head_tag   = tag_w[rd_idx];
    assign full       = vld_w[wr_idx];
    assign do_push    = push & ~full;
    assign do_pop     = pop & head_valid;

    // Step the write and read indices around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (do_push) begin
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (do_pop) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic    vld_r;
        op_tag_t tag_r;

        // Hold one tag entry and its occupancy flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
                tag_r <= '0;
            end else if (do_push && (wr_idx == IDX_W'(i))) begin
                vld_r <= 1'b1;
                tag_r <= push_tag;
            end else if (do_pop && (rd_idx == IDX_W'(i))) begin
                vld_r <= 1'b0;
            end
        end

        assign vld_w[i]   = vld_r;
        assign tag_w[i]   = tag_r;
        assign rd_hit0[i] = vld_r & tag_r.is_rd & (tag_r.owner == PORT0);
        assign rd_hit1[i] = vld_r & tag_r.is_rd & (tag_r.owner == PORT1);
    end

    assign rd_pend[0] = |rd_hit0;
    assign rd_pend[1] = |rd_hit1;

endmodule

// File: rtl/tslot_resp_route.sv
// Per-port response steering: passes controller indications to one port
// only when that port owns the current grant or the oldest tag.
// Assumes head_tag is meaningful only while head_valid is high.
module tslot_resp_route
    import tslot_pkg::*;
#(
    parameter int       DATA_W = 16,
    parameter port_id_e ME     = PORT0
) (
    input  logic              gnt_valid,
    input  port_id_e          gnt_port,
    input  logic              head_valid,
    input  op_tag_t           head_tag,
    input  logic              mc_begun,
    input  logic              mc_early_begun,
    input  logic              mc_done,
    input  logic              mc_rd_done,
    input  logic [DATA_W-1:0] mc_rdata,
    output logic              begun,
    output logic              early_begun,
    output logic              done,
    output logic              rd_done,
    output logic [DATA_W-1:0] rdata
);

    logic issue_mine;
    logic head_mine;

    // Decide whether this port owns the issue side and the completion side.
    always_comb begin
        issue_mine = gnt_valid && (gnt_port == ME);
        head_mine  = head_valid && (head_tag.owner == ME);
    end

    // Gate each indication with its owner match.
    always_comb begin
        begun       = mc_begun & issue_mine;
        early_begun = mc_early_begun & issue_mine;
        done        = mc_done & head_mine;
        rd_done     = mc_rd_done & head_mine & head_tag.is_rd;
        rdata       = rd_done ? mc_rdata : '0;
    end

endmodule

// File: rtl/tslot_mem_arbiter.sv
// Two-port memory arbiter top: time-slot scheduling onto one controller
// host interface, with per-port response steering by operation tag.
// Assumes the controller completes operations in begun order with one
// done per operation, and raises read done together with done for reads.
module tslot_mem_arbiter
    import tslot_pkg::*;
#(
    parameter int               ADDR_W    = 24,
    parameter int               DATA_W    = 16,
    parameter int               SLOTS     = 16,
    parameter logic [SLOTS-1:0] SLOT_MAP  = 16'hC0F0,
    parameter int               TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_rst_n,
    input  logic              p0_rd,
    input  logic              p0_wr,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic              p0_begun,
    output logic              p0_early_begun,
    output logic              p0_done,
    output logic              p0_rd_done,
    output logic              p0_rd_pending,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_rst_n,
    input  logic              p1_rd,
    input  logic              p1_wr,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_begun,
    output logic              p1_early_begun,
    output logic              p1_done,
    output logic              p1_rd_done,
    output logic              p1_rd_pending,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              mc_rd,
    output logic              mc_wr,
    output logic [ADDR_W-1:0] mc_addr,
    output logic [DATA_W-1:0] mc_wdata,
    input  logic              mc_begun,
    input  logic              mc_early_begun,
    input  logic              mc_done,
    input  logic              mc_rd_done,
    input  logic [DATA_W-1:0] mc_rdata
);

    logic [NUM_PORTS-1:0] p_rd;
    logic [NUM_PORTS-1:0] p_wr;
    logic [NUM_PORTS-1:0] p_req;
    logic [ADDR_W-1:0]    p_addr  [NUM_PORTS];
    logic [DATA_W-1:0]    p_wdata [NUM_PORTS];
    logic [NUM_PORTS-1:0] r_begun;
    logic [NUM_PORTS-1:0] r_early;
    logic [NUM_PORTS-1:0] r_done;
    logic [NUM_PORTS-1:0] r_rd_done;
    logic [DATA_W-1:0]    r_rdata [NUM_PORTS];
    logic [NUM_PORTS-1:0] rd_pend;

    logic     sched_gnt_valid;
    port_id_e sched_gnt_port;
    logic     tags_full;
    logic     head_valid;
    op_tag_t  head_tag;
    op_tag_t  new_tag;
    logic     sel_rd;
    logic     sel_wr;

    // Gather client inputs, masking requests of a port held in reset.
    always_comb begin
        p_rd[0]    = p0_rd & p0_rst_n;
        p_wr[0]    = p0_wr & p0_rst_n;
        p_rd[1]    = p1_rd & p1_rst_n;
        p_wr[1]    = p1_wr & p1_rst_n;
        p_addr[0]  = p0_addr;
        p_addr[1]  = p1_addr;
        p_wdata[0] = p0_wdata;
        p_wdata[1] = p1_wdata;
        p_req      = p_rd | p_wr;
    end

    tslot_sched #(
        .SLOTS    (SLOTS),
        .SLOT_MAP (SLOT_MAP)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (p_req),
        .hold_off  (tags_full),
        .mc_begun  (mc_begun),
        .gnt_valid (sched_gnt_valid),
        .gnt_port  (sched_gnt_port)
    );

    // Drive the controller request from the granted port; read wins over write.
    always_comb begin
        sel_rd   = sched_gnt_valid & p_rd[sched_gnt_port];
        sel_wr   = sched_gnt_valid & p_wr[sched_gnt_port] & ~p_rd[sched_gnt_port];
        mc_rd    = sel_rd;
        mc_wr    = sel_wr;
        mc_addr  = sched_gnt_valid ? p_addr[sched_gnt_port]  : '0;
        mc_wdata = sched_gnt_valid ? p_wdata[sched_gnt_port] : '0;
        new_tag.owner = sched_gnt_port;
        new_tag.is_rd = sel_rd;
    end

    tslot_tag_fifo #(
        .DEPTH (TAG_DEPTH)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (mc_begun & sched_gnt_valid),
        .push_tag   (new_tag),
        .pop        (mc_done),
        .head_tag   (head_tag),
        .head_valid (head_valid),
        .full       (tags_full),
        .rd_pend    (rd_pend)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        tslot_resp_route #(
            .DATA_W (DATA_W),
            .ME     (port_id_e'(g))
        ) u_route (
            .gnt_valid      (sched_gnt_valid),
            .gnt_port       (sched_gnt_port),
            .head_valid     (head_valid),
            .head_tag       (head_tag),
            .mc_begun       (mc_begun),
            .mc_early_begun (mc_early_begun),
            .mc_done        (mc_done),
            .mc_rd_done     (mc_rd_done),
            .mc_rdata       (mc_rdata),
            .begun          (r_begun[g]),
            .early_begun    (r_early[g]),
            .done           (r_done[g]),
            .rd_done        (r_rd_done[g]),
            .rdata          (r_rdata[g])
        );
    end

    // Fan the steered indications out to the named port pins.
    always_comb begin
        p0_begun       = r_begun[0];
        p0_early_begun = r_early[0];
        p0_done        = r_done[0];
        p0_rd_done     = r_rd_done[0];
        p0_rd_pending  = rd_pend[0];
        p0_rdata       = r_rdata[0];
        p1_begun       = r_begun[1];
        p1_early_begun = r_early[1];
        p1_done        = r_done[1];
        p1_rd_done     = r_rd_done[1];
        p1_rd_pending  = rd_pend[1];
        p1_rdata       = r_rdata[1];
    end

endmodule

// File: rtl/tslot_mem_arbiter_chk.sv
// Assertion checker for the two-port arbiter; attached by bind below.
// Observes ports and the scheduler's grant outputs only.
module tslot_mem_arbiter_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p0_rst_n,
    input logic              p1_rst_n,
    input logic              p0_begun,
    input logic              p1_begun,
    input logic              p0_rd_done,
    input logic              p1_rd_done,
    input logic              p0_rd_pending,
    input logic              p1_rd_pending,
    input logic [DATA_W-1:0] p0_rdata,
    input logic [DATA_W-1:0] p1_rdata,
    input logic              mc_rd,
    input logic              mc_wr,
    input logic              mc_begun,
    input logic              gnt_valid,
    input logic              gnt_port
);

    // R5
    begun_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_begun && p1_begun));

    // R6
    p0_rd_done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_rd_done |-> p0_rd_pending);

    // R6
    p1_rd_done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p1_rd_done |-> p1_rd_pending);

    // R6
    p0_rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_rd_done |-> (p0_rdata == '0));

    // R6
    p1_rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_rd_done |-> (p1_rdata == '0));

    // R12
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_rd && mc_wr));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !mc_begun) |=> (!gnt_valid || (gnt_port == $past(gnt_port))));

    // R10
    p0_rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_rst_n |-> !p0_begun);

    // R10
    p1_rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_rst_n |-> !p1_begun);

endmodule

bind tslot_mem_arbiter tslot_mem_arbiter_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .p0_rst_n      (p0_rst_n),
    .p1_rst_n      (p1_rst_n),
    .p0_begun      (p0_begun),
    .p1_begun      (p1_begun),
    .p0_rd_done    (p0_rd_done),
    .p1_rd_done    (p1_rd_done),
    .p0_rd_pending (p0_rd_pending),
    .p1_rd_pending (p1_rd_pending),
    .p0_rdata      (p0_rdata),
    .p1_rdata      (p1_rdata),
    .mc_rd         (mc_rd),
    .mc_wr         (mc_wr),
    .mc_begun      (mc_begun),
    .gnt_valid     (sched_gnt_valid),
    .gnt_port      (sched_gnt_port)
);

// File: tb/tslot_mem_arbiter_tb.sv
`timescale 1ns/1ps
// Directed bench: the bench plays both clients and the memory controller.
module tslot_mem_arbiter_tb;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam logic [15:0] MAP = 16'hC0F0;
    localparam logic [ADDR_W-1:0] A0 = 24'h000111;
    localparam logic [ADDR_W-1:0] A1 = 24'h000222;
    localparam logic [DATA_W-1:0] D0 = 16'hAAAA;
    localparam logic [DATA_W-1:0] D1 = 16'h5555;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p0_rst_n = 1'b1, p0_rd = 1'b0, p0_wr = 1'b0;
    logic [ADDR_W-1:0] p0_addr = '0;
    logic [DATA_W-1:0] p0_wdata = '0;
    logic p1_rst_n = 1'b1, p1_rd = 1'b0, p1_wr = 1'b0;
    logic [ADDR_W-1:0] p1_addr = '0;
    logic [DATA_W-1:0] p1_wdata = '0;
    logic mc_begun = 1'b0, mc_early_begun = 1'b0, mc_done = 1'b0, mc_rd_done = 1'b0;
    logic [DATA_W-1:0] mc_rdata = '0;
    logic p0_begun, p0_early_begun, p0_done, p0_rd_done, p0_rd_pending;
    logic [DATA_W-1:0] p0_rdata;
    logic p1_begun, p1_early_begun, p1_done, p1_rd_done, p1_rd_pending;
    logic [DATA_W-1:0] p1_rdata;
    logic mc_rd, mc_wr;
    logic [ADDR_W-1:0] mc_addr;
    logic [DATA_W-1:0] mc_wdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tslot_mem_arbiter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(16), .SLOT_MAP(MAP), .TAG_DEPTH(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .p0_rst_n(p0_rst_n), .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_begun(p0_begun), .p0_early_begun(p0_early_begun),
        .p0_done(p0_done), .p0_rd_done(p0_rd_done), .p0_rd_pending(p0_rd_pending),
        .p0_rdata(p0_rdata),
        .p1_rst_n(p1_rst_n), .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_begun(p1_begun), .p1_early_begun(p1_early_begun),
        .p1_done(p1_done), .p1_rd_done(p1_rd_done), .p1_rd_pending(p1_rd_pending),
        .p1_rdata(p1_rdata),
        .mc_rd(mc_rd), .mc_wr(mc_wr), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
        .mc_begun(mc_begun), .mc_early_begun(mc_early_begun), .mc_done(mc_done),
        .mc_rd_done(mc_rd_done), .mc_rdata(mc_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, where inputs change.
    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic idle_all();
        p0_rd = 0; p0_wr = 0; p1_rd = 0; p1_wr = 0;
        p0_rst_n = 1; p1_rst_n = 1;
        mc_begun = 0; mc_early_begun = 0; mc_done = 0; mc_rd_done = 0; mc_rdata = '0;
    endtask

    // R1: reset state with idle inputs.
    task automatic t_reset();
        nxt(); idle_all(); rst_n = 0;
        repeat (3) nxt();
        #1;
        check("R1 mc_rd", mc_rd, 0);
        check("R1 mc_wr", mc_wr, 0);
        check("R1 begun", {p0_begun, p1_begun, p0_early_begun, p1_early_begun}, 0);
        check("R1 done", {p0_done, p1_done, p0_rd_done, p1_rd_done}, 0);
        check("R1 pending", {p0_rd_pending, p1_rd_pending}, 0);
        nxt(); rst_n = 1;
    endtask

    // R2, R5, R11: both ports writing, every request begun at once.
    task automatic t_slots();
        logic [15:0] seq;
        int ones;
        bit found;
        t_reset();
        p0_addr = A0; p0_wdata = D0; p1_addr = A1; p1_wdata = D1;
        p0_wr = 1; p1_wr = 1; mc_begun = 1; mc_early_begun = 1; mc_done = 1;
        ones = 0;
        for (int i = 0; i < 16; i++) begin
            #1;
            seq[i] = (mc_addr == A1);
            ones += int'(seq[i]);
            check("R11 wdata follows grant", mc_wdata, seq[i] ? D1 : D0);
            check("R5 p1 begun", p1_begun, seq[i]);
            check("R5 p0 begun", p0_begun, !seq[i]);
            check("R5 p1 early begun", p1_early_begun, seq[i]);
            nxt();
        end
        found = 0;
        for (int k = 0; k < 16; k++) begin
            bit m;
            m = 1;
            for (int i = 0; i < 16; i++) if (seq[i] != MAP[(k + i) % 16]) m = 0;
            if (m) found = 1;
        end
        check("R2 rotation of slot map", found, 1);
        check("R2 port1 slot count", ones, $countones(MAP));
        idle_all();
    endtask

    // R3: a lone requester takes every slot.
    task automatic t_lone();
        int hits;
        t_reset();
        p0_addr = A0; p1_addr = A1;
        p0_wr = 1; mc_begun = 1; mc_done = 1; hits = 0;
        for (int i = 0; i < 16; i++) begin
            #1; if (mc_wr && mc_addr == A0) hits++;
            nxt();
        end
        check("R3 port0 alone", hits, 16);
        p0_wr = 0; p1_wr = 1; hits = 0;
        for (int i = 0; i < 16; i++) begin
            #1; if (mc_wr && mc_addr == A1 && p1_begun) hits++;
            nxt();
        end
        check("R3 port1 alone", hits, 16);
        idle_all();
    endtask

    // R4: grant held while the controller has not begun.
    task automatic t_lock();
        logic [ADDR_W-1:0] held;
        int moved;
        t_reset();
        repeat (5) nxt();
        p0_addr = A0; p1_addr = A1; p0_wr = 1; p1_wr = 1;
        #1; held = mc_addr; moved = 0;
        for (int i = 0; i < 20; i++) begin
            nxt(); #1;
            if (mc_addr != held || !mc_wr || p0_begun || p1_begun) moved++;
        end
        check("R4 grant held until begun", moved, 0);
        nxt(); mc_begun = 1; #1;
        check("R4 begun to held port", {p1_begun, p0_begun}, (held == A1) ? 2'b10 : 2'b01);
        nxt(); idle_all();
    endtask

    // R6, R7, R8: two pipelined reads from different ports.
    task automatic t_reads();
        t_reset();
        p0_addr = 24'h10; p1_addr = 24'h20;
        p0_rd = 1; mc_begun = 1; #1;
        check("R5 p0 read begun", {p1_begun, p0_begun}, 2'b01);
        nxt(); p0_rd = 0; p1_rd = 1; #1;
        check("R8 p0 pending after begun", {p1_rd_pending, p0_rd_pending}, 2'b01);
        check("R5 p1 read begun", {p1_begun, p0_begun}, 2'b10);
        nxt(); p1_rd = 0; mc_begun = 0; #1;
        check("R8 both pending", {p1_rd_pending, p0_rd_pending}, 2'b11);
        nxt(); mc_done = 1; mc_rd_done = 1; mc_rdata = 16'hBEEF; #1;
        check("R6 first rd_done to p0", {p1_rd_done, p0_rd_done}, 2'b01);
        check("R6 p0 rdata", p0_rdata, 16'hBEEF);
        check("R6 p1 rdata zero", p1_rdata, 0);
        check("R7 first done to p0", {p1_done, p0_done}, 2'b01);
        nxt(); mc_done = 0; mc_rd_done = 0; mc_rdata = '0; #1;
        check("R8 p0 retired", {p1_rd_pending, p0_rd_pending}, 2'b10);
        nxt(); mc_done = 1; mc_rd_done = 1; mc_rdata = 16'hCAFE; #1;
        check("R6 second rd_done to p1", {p1_rd_done, p0_rd_done}, 2'b10);
        check("R6 p1 rdata", p1_rdata, 16'hCAFE);
        check("R6 p0 rdata zero", p0_rdata, 0);
        nxt(); idle_all(); #1;
        check("R8 none pending", {p1_rd_pending, p0_rd_pending}, 2'b00);
    endtask

    // R7, R8: write done then read done, steered in begun order.
    task automatic t_write_done();
        t_reset();
        p1_addr = A1; p0_addr = A0;
        p1_wr = 1; mc_begun = 1;
        nxt(); p1_wr = 0; p0_rd = 1; #1;
        check("R8 write raises no pending", p1_rd_pending, 0);
        nxt(); p0_rd = 0; mc_begun = 0;
        nxt(); mc_done = 1; #1;
        check("R7 write done to p1", {p1_done, p0_done}, 2'b10);
        check("R7 write gives no rd_done", {p1_rd_done, p0_rd_done}, 2'b00);
        nxt(); mc_rd_done = 1; mc_rdata = 16'h1234; #1;
        check("R7 read done to p0", {p1_done, p0_done, p0_rd_done}, 3'b011);
        nxt(); idle_all();
    endtask

    // R9: no request while all tags are outstanding.
    task automatic t_full();
        t_reset();
        p0_addr = A0; p0_rd = 1; mc_begun = 1;
        for (int i = 0; i < 4; i++) begin
            #1; check("R9 accepted below depth", mc_rd, 1);
            nxt();
        end
        #1;
        check("R9 held off when full", mc_rd, 0);
        check("R9 no begun when full", p0_begun, 0);
        nxt(); mc_begun = 0; mc_done = 1; mc_rd_done = 1; mc_rdata = 16'h0F0F; #1;
        check("R9 still full during done", mc_rd, 0);
        nxt(); mc_done = 0; mc_rd_done = 0; #1;
        check("R9 resumes after retire", mc_rd, 1);
        nxt(); idle_all();
    endtask

    // R10, R11, R12: port reset masking, idle bus, read priority.
    task automatic t_misc();
        int leaks;
        t_reset();
        p0_addr = A0; p1_addr = A1; p0_wdata = D0;
        #1;
        check("R11 idle address zero", mc_addr, 0);
        check("R11 idle data zero", mc_wdata, 0);
        p0_rst_n = 0; p0_rd = 1; p1_wr = 1; mc_begun = 1; mc_done = 1; leaks = 0;
        for (int i = 0; i < 16; i++) begin
            #1; if (mc_rd || p0_begun || mc_addr != A1) leaks++;
            nxt();
        end
        check("R10 port0 in reset ignored", leaks, 0);
        p0_rst_n = 1; p0_wr = 1; p1_wr = 0; #1;
        check("R12 rd+wr issued as read", {mc_rd, mc_wr}, 2'b10);
        nxt(); idle_all();
    endtask

    initial begin
        t_reset();
        t_slots();
        t_lone();
        t_lock();
        t_reads();
        t_write_done();
        t_full();
        t_misc();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule